// File: doc/BRIEF.md
# Nibble-Serial GHASH Multiplier

This block multiplies a 128-bit accumulator by a fixed hash key in GF(2^128), using the bit ordering that GCM authentication uses. It takes four bits of the operand per clock. Each step looks up a precomputed multiple of the key in a 16-entry table that software loads. It folds the four bits shifted out of the bottom back into the top 16 bits through a fixed 16-entry remainder table. A full multiply takes 32 clock cycles.

A host first writes the 16 key multiples through the table write port. Entry n must hold the key times the 4-bit polynomial n, where bit 3 of n is the coefficient of x^0 and bit 0 is the coefficient of x^3. After that, the host pulses `start` for each multiply. With `absorb` low, the stored accumulator is multiplied as it is. With `absorb` high, the 16-byte block on `blk` is XORed into the accumulator first. Pulsing `start` with `absorb` high once per block computes a GHASH over a stream whose length is a whole number of blocks. The stream ends when the host stops issuing blocks. The result stays on `acc` until the next start.

Top module: `ghash_nibble_mul`

## Requirements
- R1: A synchronous active-high `rst` clears `acc` to zero and leaves `busy` and `done` low.
- R2: When `tbl_we` is high and the block is idle, entry `tbl_addr` takes `tbl_data`. Entry n is the key times the nibble n, with bit 3 of n as the coefficient of x^0. Table contents survive `rst`.
- R3: A table write presented while `busy` is high is ignored, so later multiplies still use the old entry.
- R4: A `start` sampled while idle with `absorb` low replaces `acc` with `acc` times the key. `done` is high for exactly one cycle, 32 cycles after the sampling edge, and `acc` holds the product in that same cycle. `busy` is high from the cycle after the sampling edge until `done`.
- R5: A `start` sampled while idle with `absorb` high replaces `acc` with (`acc` XOR `blk`) times the key.
- R6: A chain of absorbing starts over blocks B1..Bn leaves `acc` equal to the GHASH of those blocks under the key, starting from the accumulator value before the chain.
- R7: While no multiply is running and no start is sampled, `acc` holds its value. A `start` that arrives while `busy` is high is ignored, and neither the result nor the timing changes.
- R8: Byte 0 of a block sits at bits 127:120. Within each byte, the most significant bit is the coefficient of the lowest power of x. So after reset, absorbing the block 0x80 followed by fifteen zero bytes yields exactly table entry 8, which is the key.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 4 | Table entry index |
| tbl_data | input | 128 | Table entry value |
| start | input | 1 | Begin a multiply when idle |
| absorb | input | 1 | XOR `blk` into the accumulator at start |
| blk | input | 128 | Input block, byte 0 in bits 127:120 |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | One-cycle pulse at completion |
| acc | output | 128 | Accumulator / result |

## Verification
The assertions assume that `start` is only meaningful when idle, and that reset is held for at least one clock so that the counter and the flags start clean. They do not check the table contents. They assume the table holds consistent key multiples, which is why the stimulus loads every entry from an independent bit-serial product before any multiply. Table writes and starts are driven during a multiply only on purpose, to show that they are ignored. Inputs change on the falling edge, so every value sampled on the rising edge is settled.

// File: rtl/ghash_nibble_mul.sv
module ghash_nibble_mul (
  input  logic         clk,
  input  logic         rst,
  input  logic         tbl_we,
  input  logic [3:0]   tbl_addr,
  input  logic [127:0] tbl_data,
  input  logic         start,
  input  logic         absorb,
  input  logic [127:0] blk,
  output logic         busy,
  output logic         done,
  output logic [127:0] acc
);
  localparam int STEPS = 32;
  localparam logic [4:0] LAST = 5'(STEPS - 1);

  logic [127:0] kmul [16];
  logic [127:0] z, x;
  logic [4:0]   cnt;

  function automatic logic [15:0] fold(input logic [3:0] r);
    case (r)
      4'h0: fold = 16'h0000; 4'h1: fold = 16'h1C20;
      4'h2: fold = 16'h3840; 4'h3: fold = 16'h2460;
      4'h4: fold = 16'h7080; 4'h5: fold = 16'h6CA0;
      4'h6: fold = 16'h48C0; 4'h7: fold = 16'h54E0;
      4'h8: fold = 16'hE100; 4'h9: fold = 16'hFD20;
      4'hA: fold = 16'hD940; 4'hB: fold = 16'hC560;
      4'hC: fold = 16'h9180; 4'hD: fold = 16'h8DA0;
      4'hE: fold = 16'hA9C0; default: fold = 16'hB5E0;
    endcase
  endfunction

  wire [127:0] reduced = (z >> 4) ^ {fold(z[3:0]), 112'b0};
  wire [127:0] z_next  = ((cnt == 5'd0) ? 128'b0 : reduced) ^ kmul[x[3:0]];

  assign acc = z;

  always_ff @(posedge clk) begin
    if (tbl_we && !busy) kmul[tbl_addr] <= tbl_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      z    <= '0;
      x    <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          x    <= z ^ (absorb ? blk : 128'b0);
          cnt  <= '0;
          busy <= 1'b1;
        end
      end else begin
        z   <= z_next;
        x   <= x >> 4;
        cnt <= cnt + 5'd1;
        if (cnt == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_ends_busy_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && !busy));
  assert_start_engages_R4: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  assert_acc_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(acc));
  assert_busy_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != LAST) |=> (busy && !done));
endmodule

// File: tb/sim_ghash_nibble_mul.sv
module sim_ghash_nibble_mul;
  logic clk = 0, rst = 1, tbl_we = 0, start = 0, absorb = 0;
  logic [3:0] tbl_addr = 0;
  logic [127:0] tbl_data = 0, blk = 0;
  logic busy, done;
  logic [127:0] acc;
  int total = 0, bad = 0;
  logic [127:0] key, ref_acc;

  always #10 clk = ~clk;

  ghash_nibble_mul u0 (.clk, .rst, .tbl_we, .tbl_addr, .tbl_data, .start,
                       .absorb, .blk, .busy, .done, .acc);

  function automatic logic [127:0] gmul(input logic [127:0] a, input logic [127:0] b);
    logic [127:0] r = 0, v = b;
    for (int i = 0; i < 128; i++) begin
      if (a[127-i]) r ^= v;
      v = v[0] ? ((v >> 1) ^ {8'hE1, 120'b0}) : (v >> 1);
    end
    return r;
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_table(input logic [127:0] h, input logic [3:0] skip_bad, input logic use_bad);
    for (int n = 0; n < 16; n++) begin
      @(negedge clk);
      tbl_we = 1; tbl_addr = 4'(n);
      tbl_data = (use_bad && 4'(n) == skip_bad) ? 128'hDEAD : gmul({4'(n), 124'b0}, h);
    end
    @(negedge clk); tbl_we = 0;
  endtask

  task automatic run_op(input logic ab, input logic [127:0] b, input int poke, output int cyc);
    @(negedge clk);
    start = 1; absorb = ab; blk = b;
    @(negedge clk);
    start = 0; absorb = 0; blk = 0;
    cyc = 1;
    while (!done && cyc < 100) begin
      if (cyc == poke) begin
        tbl_we = 1; tbl_addr = 4'h8; tbl_data = 128'h1234;
        start = 1; absorb = 1; blk = {128{1'b1}};
      end
      @(negedge clk);
      tbl_we = 0; start = 0; absorb = 0; blk = 0;
      cyc++;
    end
  endtask

  task automatic t_reset;
    rst = 1; repeat (2) @(negedge clk); rst = 0;
    chk("R1 acc", acc, 0);
    chk("R1 busy/done", {126'b0, busy, done}, 0);
    ref_acc = 0;
  endtask

  task automatic t_order;
    int c;
    run_op(1, {8'h80, 120'b0}, 0, c);
    chk("R8 unit block gives key", acc, key);
    ref_acc = key;
  endtask

  task automatic t_single;
    int c;
    ref_acc = gmul(ref_acc, key);
    run_op(0, 128'hFFFF, 0, c);
    chk("R4 product", acc, ref_acc);
    chk("R4 latency", 128'(c), 33);
    @(negedge clk);
    chk("R4 done one cycle", {127'b0, done}, 0);
  endtask

  task automatic t_absorb(input logic [127:0] b);
    int c;
    ref_acc = gmul(ref_acc ^ b, key);
    run_op(1, b, 0, c);
    chk("R5 absorb product", acc, ref_acc);
  endtask

  task automatic t_stream;
    int c;
    logic [127:0] g = acc;
    for (int k = 0; k < 4; k++) begin
      logic [127:0] b = {4{32'h9E3779B9 * (k + 3)}} ^ (128'h1 << (k * 37));
      g = gmul(g ^ b, key);
      run_op(1, b, 0, c);
    end
    chk("R6 stream GHASH", acc, g);
    ref_acc = g;
  endtask

  task automatic t_hold;
    logic [127:0] held = acc;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); absorb = k[0]; blk = {4{32'(k * 1234567)}};
    end
    @(negedge clk); absorb = 0; blk = 0;
    chk("R7 acc held while idle", acc, held);
  endtask

  task automatic t_start_busy;
    int c;
    ref_acc = gmul(ref_acc ^ 128'h55, key);
    @(negedge clk);
    start = 1; absorb = 1; blk = 128'h55;
    @(negedge clk);
    start = 0; absorb = 0; blk = 0;
    c = 1;
    while (!done && c < 100) begin
      if (c == 10) begin start = 1; absorb = 1; blk = {128{1'b1}}; end
      @(negedge clk);
      start = 0; absorb = 0; blk = 0;
      c++;
    end
    chk("R7 start while busy ignored", acc, ref_acc);
    chk("R7 latency kept", 128'(c), 33);
  endtask

  task automatic t_busy_write;
    int c;
    ref_acc = gmul(ref_acc, key);
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    @(negedge clk);
    tbl_we = 1; tbl_addr = 4'h8; tbl_data = 128'h1234;
    @(negedge clk);
    tbl_we = 0;
    while (!done) @(negedge clk);
    chk("R3 product during write", acc, ref_acc);
    ref_acc = gmul(ref_acc ^ {8'h88, 120'h0123456789ABCDEF}, key);
    run_op(1, {8'h88, 120'h0123456789ABCDEF}, 0, c);
    chk("R3 entry untouched", acc, ref_acc);
  endtask

  task automatic t_reset_keeps;
    int c;
    t_reset;
    run_op(1, {8'h80, 120'b0}, 0, c);
    chk("R2 table survives reset", acc, key);
    ref_acc = key;
  endtask

  task automatic t_rewrite;
    int c;
    logic [127:0] k2 = 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0;
    load_table(k2, 0, 0);
    t_reset;
    run_op(1, {8'h80, 120'b0}, 0, c);
    chk("R2 rewritten key entry", acc, k2);
    ref_acc = gmul(k2 ^ 128'hC0FFEE, k2);
    run_op(1, 128'hC0FFEE, 0, c);
    chk("R2 rewritten table product", acc, ref_acc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    key = 128'h66E94BD4EF8A2C3B884CFA59CA342B2E;
    load_table(key, 0, 0);
    t_reset;
    t_order;
    t_single;
    t_absorb(128'h0388DACE60B6A392F328C2B971B2FE78);
    t_absorb({128{1'b1}});
    t_absorb(128'h1);
    t_stream;
    t_hold;
    t_start_busy;
    t_busy_write;
    t_reset_keeps;
    t_single;
    t_rewrite;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule